// File: doc/BRIEF.md
# Endpoint FIFO Byte Window

This block gives a processor byte-level access to up to sixteen endpoint packet buffers through a small address window. Each endpoint owns a four-byte slot. A bus access of 8, 16 or 32 bits that lands in a slot is broken into single-byte operations, lowest byte lane first. Writes feed the endpoint's transmit side and reads drain its receive side. All buffers live in one shared 2 KB single-port byte RAM, so the block holds the bus off with a ready signal while it works through the bytes.

For each endpoint the block keeps a transmit fill count and a receive read count, both capped at one packet of 64 bytes. A configurable base offset sets where each direction's buffer starts. Control-register write strobes carry the flush commands. A receive-arm strobe marks a freshly landed packet. The block reports a transmit-not-empty flag and a receive-full flag for every endpoint.

Top module: `ep_fifo_window`

## Requirements
- R1: An access at address A with 0x20 <= A <= 0x5F selects endpoint ((A - 0x20) >> 2) & 0xF. An access outside that range changes no count, no buffer byte and no flag, and a read there returns 0.
- R2: reqSize 0 performs one byte operation, 1 performs two and 2 performs four. Lane 0 (bits 7:0) goes first, then lanes 1, 2 and 3 in rising order, each at the next buffer offset. Read lanes that are not used return 0.
- R3: The transmit base and the receive base of an endpoint are (baseWrData << 3) taken to 11 bits. A written byte is stored at transmit base + fill count, and the fill count then increases by one.
- R4: A transmit byte that is stored sets that endpoint's txNotEmpty bit.
- R5: Once an endpoint's fill count is 64, further write bytes to it are discarded and no buffer byte changes.
- R6: A read byte returns the RAM byte at receive base + read count, increases the read count by one and clears that endpoint's rxFull bit.
- R7: Once an endpoint's read count is 64, read bytes return 0x00 and the read count stays where it is.
- R8: reqReady is low for exactly N cycles after an accepted access, where N is its byte count. A read gives a one-cycle rspValid carrying the assembled data one cycle after its last byte operation.
- R9: A transmit control write (csrWrTx = 1) flushes the transmit side: bit 3 on endpoints 1 to 15, bit 8 on endpoint 0. The flush zeroes the fill count and clears txNotEmpty. Bit 3 has no flush effect on endpoint 0.
- R10: A receive control write (csrWrTx = 0) with bit 4 set zeroes that endpoint's read count and clears rxFull.
- R11: rxArmValid sets rxFull of rxArmEp and zeroes its read count.
- R12: After reset every count is 0, txNotEmpty and rxFull are all 0 and reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus access request |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Byte address of the access |
| reqSize | input | 2 | 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit |
| reqWdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rspValid | output | 1 | Read data valid for one cycle |
| rspRdata | output | 32 | Assembled read data |
| baseWrValid | input | 1 | Load a buffer base register |
| baseWrEp | input | 4 | Endpoint of the base load |
| baseWrTx | input | 1 | 1 = transmit base, 0 = receive base |
| baseWrData | input | 8 | Base in units of 8 bytes |
| csrWrValid | input | 1 | Control-register write strobe |
| csrWrEp | input | 4 | Endpoint of the control write |
| csrWrTx | input | 1 | 1 = transmit control, 0 = receive control |
| csrWrData | input | 16 | Control write value (flush bits) |
| rxArmValid | input | 1 | A received packet is ready in the buffer |
| rxArmEp | input | 4 | Endpoint that received it |
| txNotEmpty | output | 16 | Per-endpoint transmit-not-empty flag |
| rxFull | output | 16 | Per-endpoint receive-full flag |

## Verification
The assertions assume that no flush, arm or base load targets the endpoint that is being accessed in the same cycle. They also assume that reqValid is only raised while the block is in a defined state after reset. The stimulus keeps to this by issuing control strobes only between bus accesses, each for a single cycle, with reqValid held low. Reads target only buffer bytes that earlier writes filled, so every expected value is defined by the bench's own byte model of the shared RAM.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  localparam int EP_W   = 4;
  localparam int LANE_W = 2;
  localparam int BYTE_W = 8;

  // One byte operation, issued by the sequencer to the datapath.
  typedef struct packed {
    logic              doByte;
    logic              write;
    logic              hit;
    logic [EP_W-1:0]   ep;
    logic [LANE_W-1:0] lane;
    logic              last;
    logic [BYTE_W-1:0] wbyte;
  } laneStrobeT;
endpackage

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl
  import ep_fifo_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WIN_BASE = 32,
  parameter int NUM_EP   = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output laneStrobeT        strobe
);
  localparam int WIN_END = WIN_BASE + 4 * NUM_EP;

  logic              busyQ;
  logic              opWriteQ;
  logic              opHitQ;
  logic [EP_W-1:0]   opEpQ;
  logic [LANE_W-1:0] laneQ;
  logic [LANE_W-1:0] lastLaneQ;
  logic [DATA_W-1:0] wdataQ;

  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic [LANE_W-1:0] lastLaneD;
  logic              accept;

  assign offset   = reqAddr - ADDR_W'(WIN_BASE);
  assign inWindow = (int'(reqAddr) >= WIN_BASE) && (int'(reqAddr) < WIN_END);
  assign reqReady = !busyQ;
  assign accept   = reqValid && reqReady;

  always_comb begin
    case (reqSize)
      2'd0:    lastLaneD = LANE_W'(0);
      2'd1:    lastLaneD = LANE_W'(1);
      default: lastLaneD = LANE_W'(3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      opWriteQ  <= 1'b0;
      opHitQ    <= 1'b0;
      opEpQ     <= '0;
      laneQ     <= '0;
      lastLaneQ <= '0;
      wdataQ    <= '0;
    end else if (accept) begin
      busyQ     <= 1'b1;
      opWriteQ  <= reqWrite;
      opHitQ    <= inWindow;
      opEpQ     <= offset[2 +: EP_W];
      laneQ     <= '0;
      lastLaneQ <= lastLaneD;
      wdataQ    <= reqWdata;
    end else if (busyQ) begin
      if (laneQ == lastLaneQ) busyQ <= 1'b0;
      else                    laneQ <= laneQ + 1'b1;
    end
  end

  always_comb begin
    strobe.doByte = busyQ;
    strobe.write  = opWriteQ;
    strobe.hit    = opHitQ;
    strobe.ep     = opEpQ;
    strobe.lane   = laneQ;
    strobe.last   = (laneQ == lastLaneQ);
    strobe.wbyte  = wdataQ[{laneQ, 3'b000} +: BYTE_W];
  end

  // An accepted request holds the bus off on the following cycle.
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // Lanes advance one by one in rising order until the last one.
  assert_lane_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doByte && !strobe.last) |=> (strobe.doByte && strobe.lane == $past(strobe.lane) + 1'b1));

  // The final lane releases the bus.
  assert_release_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doByte && strobe.last) |=> reqReady);
endmodule

// File: rtl/ep_fifo_dp.sv
module ep_fifo_dp
  import ep_fifo_pkg::*;
#(
  parameter int NUM_EP        = 16,
  parameter int PKT_CAP       = 64,
  parameter int MEM_AW        = 11,
  parameter int DATA_W        = 32,
  parameter int CSR_W         = 16,
  parameter int TX_FLUSH_BIT0 = 8,
  parameter int TX_FLUSH_BITN = 3,
  parameter int RX_FLUSH_BIT  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStrobeT          strobe,
  input  logic                baseWrValid,
  input  logic [EP_W-1:0]     baseWrEp,
  input  logic                baseWrTx,
  input  logic [MEM_AW-4:0]   baseWrData,
  input  logic                csrWrValid,
  input  logic [EP_W-1:0]     csrWrEp,
  input  logic                csrWrTx,
  input  logic [CSR_W-1:0]    csrWrData,
  input  logic                rxArmValid,
  input  logic [EP_W-1:0]     rxArmEp,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [NUM_EP-1:0]   txNotEmpty,
  output logic [NUM_EP-1:0]   rxFull
);
  localparam int CNT_W   = $clog2(PKT_CAP + 1);
  localparam int MEM_D   = 1 << MEM_AW;
  localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(PKT_CAP);

  logic [CNT_W-1:0]  txFill [NUM_EP];
  logic [CNT_W-1:0]  rxRead [NUM_EP];
  logic [MEM_AW-1:0] txBase [NUM_EP];
  logic [MEM_AW-1:0] rxBase [NUM_EP];
  logic [NUM_EP-1:0] flushTxVec;
  logic [NUM_EP-1:0] flushRxVec;
  logic [NUM_EP-1:0] armVec;

  logic [BYTE_W-1:0] mem [MEM_D];
  logic [BYTE_W-1:0] ramQ;
  logic [MEM_AW-1:0] ramAddr;
  logic              canWrite;
  logic              canRead;

  logic              pendValidQ;
  logic              pendLastQ;
  logic              pendZeroQ;
  logic [LANE_W-1:0] pendLaneQ;
  logic              rspValidQ;
  logic [DATA_W-1:0] rdataQ;

  assign canWrite = strobe.doByte && strobe.write && strobe.hit &&
                    (txFill[strobe.ep] < CAP_CNT);
  assign canRead  = strobe.doByte && !strobe.write && strobe.hit &&
                    (rxRead[strobe.ep] < CAP_CNT);
  assign ramAddr  = strobe.write ? (txBase[strobe.ep] + MEM_AW'(txFill[strobe.ep]))
                                 : (rxBase[strobe.ep] + MEM_AW'(rxRead[strobe.ep]));

  // Single-port byte RAM shared by all endpoints and both directions.
  always_ff @(posedge clk) begin
    if (canWrite) mem[ramAddr] <= strobe.wbyte;
    ramQ <= mem[ramAddr];
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam int FLUSH_BIT = (i == 0) ? TX_FLUSH_BIT0 : TX_FLUSH_BITN;
    logic [CNT_W-1:0]  fillQ;
    logic [CNT_W-1:0]  readQ;
    logic [MEM_AW-1:0] txBaseQ;
    logic [MEM_AW-1:0] rxBaseQ;
    logic              notEmptyQ;
    logic              fullQ;
    logic              wrHere;
    logic              rdHere;

    assign flushTxVec[i] = csrWrValid && csrWrTx && (csrWrEp == EP_W'(i)) && csrWrData[FLUSH_BIT];
    assign flushRxVec[i] = csrWrValid && !csrWrTx && (csrWrEp == EP_W'(i)) && csrWrData[RX_FLUSH_BIT];
    assign armVec[i]     = rxArmValid && (rxArmEp == EP_W'(i));
    assign wrHere        = canWrite && (strobe.ep == EP_W'(i));
    assign rdHere        = canRead && (strobe.ep == EP_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fillQ     <= '0;
        readQ     <= '0;
        txBaseQ   <= '0;
        rxBaseQ   <= '0;
        notEmptyQ <= 1'b0;
        fullQ     <= 1'b0;
      end else begin
        if (baseWrValid && (baseWrEp == EP_W'(i))) begin
          if (baseWrTx) txBaseQ <= {baseWrData, 3'b000};
          else          rxBaseQ <= {baseWrData, 3'b000};
        end
        if (flushTxVec[i]) begin
          fillQ     <= '0;
          notEmptyQ <= 1'b0;
        end else if (wrHere) begin
          fillQ     <= fillQ + 1'b1;
          notEmptyQ <= 1'b1;
        end
        if (flushRxVec[i]) begin
          readQ <= '0;
          fullQ <= 1'b0;
        end else if (armVec[i]) begin
          readQ <= '0;
          fullQ <= 1'b1;
        end else if (rdHere) begin
          readQ <= readQ + 1'b1;
          fullQ <= 1'b0;
        end
      end
    end

    assign txFill[i]     = fillQ;
    assign rxRead[i]     = readQ;
    assign txBase[i]     = txBaseQ;
    assign rxBase[i]     = rxBaseQ;
    assign txNotEmpty[i] = notEmptyQ;
    assign rxFull[i]     = fullQ;
  end

  // Read-return pipeline: the RAM answers one cycle after the lane issues.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValidQ <= 1'b0;
      pendLastQ  <= 1'b0;
      pendZeroQ  <= 1'b0;
      pendLaneQ  <= '0;
      rspValidQ  <= 1'b0;
      rdataQ     <= '0;
    end else begin
      pendValidQ <= strobe.doByte && !strobe.write;
      pendLastQ  <= strobe.last;
      pendZeroQ  <= !canRead;
      pendLaneQ  <= strobe.lane;
      rspValidQ  <= pendValidQ && pendLastQ;
      if (pendValidQ) begin
        if (pendLaneQ == '0)
          rdataQ <= {{(DATA_W-BYTE_W){1'b0}}, (pendZeroQ ? '0 : ramQ)};
        else
          rdataQ[{pendLaneQ, 3'b000} +: BYTE_W] <= pendZeroQ ? '0 : ramQ;
      end
    end
  end

  assign rspValid = rspValidQ;
  assign rspRdata = rdataQ;

  assert_tx_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doByte && strobe.write && strobe.hit && txFill[strobe.ep] == CAP_CNT &&
     !flushTxVec[strobe.ep]) |=> txFill[$past(strobe.ep)] == CAP_CNT);

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doByte && !strobe.write && strobe.hit && rxRead[strobe.ep] == CAP_CNT &&
     !flushRxVec[strobe.ep] && !armVec[strobe.ep]) |=> rxRead[$past(strobe.ep)] == CAP_CNT);

  assert_not_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (canWrite && !flushTxVec[strobe.ep]) |=> txNotEmpty[$past(strobe.ep)]);

  assert_tx_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrValid && csrWrTx && flushTxVec[csrWrEp]) |=>
      (txFill[$past(csrWrEp)] == '0 && !txNotEmpty[$past(csrWrEp)]));

  assert_arm_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxArmValid && !flushRxVec[rxArmEp]) |=> (rxFull[$past(rxArmEp)] && rxRead[$past(rxArmEp)] == '0));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    txFill[strobe.ep] <= CAP_CNT);
endmodule

// File: rtl/ep_fifo_window.sv
module ep_fifo_window
  import ep_fifo_pkg::*;
#(
  parameter int NUM_EP  = 16,
  parameter int PKT_CAP = 64,
  parameter int MEM_AW  = 11,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CSR_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  input  logic                baseWrValid,
  input  logic [EP_W-1:0]     baseWrEp,
  input  logic                baseWrTx,
  input  logic [MEM_AW-4:0]   baseWrData,
  input  logic                csrWrValid,
  input  logic [EP_W-1:0]     csrWrEp,
  input  logic                csrWrTx,
  input  logic [CSR_W-1:0]    csrWrData,
  input  logic                rxArmValid,
  input  logic [EP_W-1:0]     rxArmEp,
  output logic [NUM_EP-1:0]   txNotEmpty,
  output logic [NUM_EP-1:0]   rxFull
);
  laneStrobeT strobe;

  ep_fifo_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(32), .NUM_EP(NUM_EP), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqReady(reqReady), .strobe(strobe)
  );

  ep_fifo_dp #(
    .NUM_EP(NUM_EP), .PKT_CAP(PKT_CAP), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CSR_W(CSR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseWrValid(baseWrValid), .baseWrEp(baseWrEp), .baseWrTx(baseWrTx), .baseWrData(baseWrData),
    .csrWrValid(csrWrValid), .csrWrEp(csrWrEp), .csrWrTx(csrWrTx), .csrWrData(csrWrData),
    .rxArmValid(rxArmValid), .rxArmEp(rxArmEp),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .txNotEmpty(txNotEmpty), .rxFull(rxFull)
  );
endmodule

// File: tb/ep_fifo_window_tb_top.sv
`timescale 1ns/1ps
module ep_fifo_window_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        baseWrValid = 1'b0;
  logic [3:0]  baseWrEp = '0;
  logic        baseWrTx = 1'b0;
  logic [7:0]  baseWrData = '0;
  logic        csrWrValid = 1'b0;
  logic [3:0]  csrWrEp = '0;
  logic        csrWrTx = 1'b0;
  logic [15:0] csrWrData = '0;
  logic        rxArmValid = 1'b0;
  logic [3:0]  rxArmEp = '0;
  logic [15:0] txNotEmpty;
  logic [15:0] rxFull;

  always #2.5 clk = ~clk;

  ep_fifo_window dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .baseWrValid(baseWrValid), .baseWrEp(baseWrEp), .baseWrTx(baseWrTx),
    .baseWrData(baseWrData), .csrWrValid(csrWrValid), .csrWrEp(csrWrEp), .csrWrTx(csrWrTx),
    .csrWrData(csrWrData), .rxArmValid(rxArmValid), .rxArmEp(rxArmEp),
    .txNotEmpty(txNotEmpty), .rxFull(rxFull)
  );

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference model built from the requirements
  logic [7:0]  mMem [2048];
  int          mFill [16];
  int          mRead [16];
  int          mTxBase [16];
  int          mRxBase [16];
  logic [15:0] mNotEmpty = '0;
  logic [15:0] mFull = '0;

  logic [31:0] expQ [$];
  string       tagQ [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag);
    check({tag, " txNotEmpty"}, {16'h0, txNotEmpty}, {16'h0, mNotEmpty});
    check({tag, " rxFull"}, {16'h0, rxFull}, {16'h0, mFull});
  endtask

  // Monitor: pops the scoreboard whenever a read response appears
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        applied++;
        miscompares++;
        $display("FAIL R8 unexpected response actual=0x%08h expected=none", rspRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, rspRdata, e);
      end
    end
  end

  // Driver: updates the model, queues expectations, drives the handshake
  task automatic access(input bit wr, input logic [7:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, input string tag);
    automatic int n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    automatic bit hit = (addr >= 8'h20) && (addr < 8'h60);
    automatic int ep = ((int'(addr) - 32) >> 2) & 15;
    automatic logic [31:0] exp = '0;
    automatic int busy = 0;
    for (int l = 0; l < n; l++) begin
      if (wr && hit && mFill[ep] < 64) begin
        mMem[(mTxBase[ep] + mFill[ep]) & 2047] = wd[l*8 +: 8];
        mFill[ep]++;
        mNotEmpty[ep] = 1'b1;
      end else if (!wr && hit && mRead[ep] < 64) begin
        exp[l*8 +: 8] = mMem[(mRxBase[ep] + mRead[ep]) & 2047];
        mRead[ep]++;
        mFull[ep] = 1'b0;
      end
    end
    if (!wr) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = size; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) begin busy++; @(negedge clk); end
    check("R8 busy cycles", 32'(busy), 32'(n));
  endtask

  task automatic setBase(input int ep, input bit tx, input logic [7:0] v);
    @(negedge clk);
    baseWrValid = 1'b1; baseWrEp = 4'(ep); baseWrTx = tx; baseWrData = v;
    @(negedge clk);
    baseWrValid = 1'b0;
    if (tx) mTxBase[ep] = int'(v) * 8; else mRxBase[ep] = int'(v) * 8;
  endtask

  task automatic csrWrite(input int ep, input bit tx, input logic [15:0] v);
    @(negedge clk);
    csrWrValid = 1'b1; csrWrEp = 4'(ep); csrWrTx = tx; csrWrData = v;
    @(negedge clk);
    csrWrValid = 1'b0;
    if (tx && ((ep == 0) ? v[8] : v[3])) begin mFill[ep] = 0; mNotEmpty[ep] = 1'b0; end
    if (!tx && v[4]) begin mRead[ep] = 0; mFull[ep] = 1'b0; end
  endtask

  task automatic arm(input int ep);
    @(negedge clk);
    rxArmValid = 1'b1; rxArmEp = 4'(ep);
    @(negedge clk);
    rxArmValid = 1'b0;
    mRead[ep] = 0; mFull[ep] = 1'b1;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", 32'(expQ.size()), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mFill[i] = 0; mRead[i] = 0; mTxBase[i] = 0; mRxBase[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 reqReady", {31'h0, reqReady}, 32'h1);
    checkFlags("R12");

    // R3 R4 R6 R11 R2: basic write then read through ep2
    setBase(2, 1'b1, 8'h10);
    setBase(2, 1'b0, 8'h10);
    access(1'b1, 8'h28, 2'd2, 32'h44332211, "R2 write");
    checkFlags("R4 after word write");
    arm(2);
    checkFlags("R11 after arm");
    access(1'b0, 8'h2B, 2'd0, '0, "R6 byte read");
    checkFlags("R6 full cleared");
    access(1'b0, 8'h29, 2'd1, '0, "R2 half read");
    access(1'b0, 8'h28, 2'd0, '0, "R3 byte at offset 3");
    drain();

    // R10: receive flush restarts reads at offset 0
    arm(2);
    csrWrite(2, 1'b0, 16'h0010);
    checkFlags("R10 after rx flush");
    access(1'b0, 8'h28, 2'd1, '0, "R10 read after flush");
    drain();

    // Neighbour guard bytes for the cap test (ep6 at 0x240)
    setBase(6, 1'b1, 8'h48);
    setBase(6, 1'b0, 8'h48);
    access(1'b1, 8'h38, 2'd2, 32'hA5B6C7D8, "R5 guard write");

    // R5 R7: overrun ep5 (base 0x200) with 68 bytes
    setBase(5, 1'b1, 8'h40);
    setBase(5, 1'b0, 8'h40);
    for (int w = 0; w < 17; w++)
      access(1'b1, 8'h34, 2'd2, 32'h03020100 + 32'h04040404 * 32'(w), "R5 fill");
    arm(5);
    for (int w = 0; w < 16; w++) access(1'b0, 8'h36, 2'd2, '0, "R5 stored bytes");
    access(1'b0, 8'h34, 2'd2, '0, "R7 exhausted word");
    access(1'b0, 8'h35, 2'd0, '0, "R7 exhausted byte");
    arm(6);
    access(1'b0, 8'h38, 2'd2, '0, "R5 neighbour untouched");
    drain();
    checkFlags("R7 flags");

    // R9: transmit flush on a data endpoint and on endpoint 0
    csrWrite(5, 1'b1, 16'h0008);
    checkFlags("R9 ep5 flush");
    access(1'b1, 8'h34, 2'd0, 32'h00000077, "R9 write after flush");
    arm(5);
    access(1'b0, 8'h34, 2'd0, '0, "R9 restart at base");
    access(1'b1, 8'h20, 2'd1, 32'h0000BEEF, "R9 ep0 write");
    csrWrite(0, 1'b1, 16'h0008);
    checkFlags("R9 ep0 ignores bit 3");
    csrWrite(0, 1'b1, 16'h0100);
    checkFlags("R9 ep0 bit 8 flush");
    drain();

    // R1: window edges and out-of-window accesses
    setBase(15, 1'b1, 8'h80);
    setBase(15, 1'b0, 8'h80);
    access(1'b1, 8'h5F, 2'd0, 32'h0000005A, "R1 top slot write");
    arm(15);
    access(1'b1, 8'h60, 2'd2, 32'hDEADBEEF, "R1 above window");
    access(1'b1, 8'h1F, 2'd2, 32'hCAFEF00D, "R1 below window");
    checkFlags("R1 flags after misses");
    access(1'b0, 8'h60, 2'd2, '0, "R1 read above window");
    access(1'b0, 8'h5C, 2'd0, '0, "R1 top slot read");
    access(1'b0, 8'h1F, 2'd1, '0, "R1 read below window");
    drain();
    checkFlags("R1 final flags");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      applied++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule